// File: doc/BRIEF.md
# Multiplexed Address/Data Register Slave

This block is a register-access target on a processor bus where address and data travel over one 16-bit bus. Every input and output is sampled on, or changes with, the single processor clock. The processor is always the master and this block is always the slave. The processor places a word address on the bus and pulses the address strobe. The block captures that address on the strobe's falling edge, but only while chip select is low.

Each accepted access passes through four phases in a fixed order. It starts with one access phase. A parameterised number of wait phases follows. Then comes one data phase, in which ready is driven low and read data is driven onto the bus. It ends with one recovery phase, in which the bus is released.

Behind the bus sit eight 16-bit locations:

- five general read/write scratch words;
- an interrupt mask;
- a read-only event status word;
- a clear port.

An active-low interrupt is raised while any status bit is also enabled in the mask.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset, ready (`rdy_n`) and interrupt (`irq_n`) are high, the bus output enable (`bus_oe`) is low, and every location reads back as zero.
- R2: The word address is `{ad_in[15:2], lane1}`. It is taken from the last clock in which `ale` was high, and an access starts on the first clock where `ale` is seen low after being high while `cs_n` is low. Address bits `ad_in[15:4]` must be zero for a mapped location. The location index is `{ad_in[3:2], lane1}`.
- R3: With `cs_n` high at the strobe's falling edge, no access takes place: `rdy_n` stays high and no location changes.
- R4: `wr_dir` high selects a write and low selects a read. A write stores the `ad_in` value present during the data phase.
- R5: Counting clock edges after the one that detects the falling strobe, `rdy_n` is low during exactly one clock. That clock is the one after edge number NWAIT+1, which is access plus NWAIT wait phases.
- R6: `bus_oe` is high only in the data phase of a read, together with low `rdy_n`. It is low in the strobe phase, the access phase, the wait phases and the recovery phase.
- R7: A read of an unmapped address returns zero, and a write to an unmapped address changes nothing.
- R8: Index 0 to 4 are scratch words, index 5 is the interrupt mask, and index 6 is the status word. Writes to index 6 are ignored.
- R9: Each bit of `evt` set high for a clock sets the matching status bit. Writing to index 7 clears every status bit that is one in the written data. A read of index 7 returns status AND mask.
- R10: `irq_n` is low exactly when status AND mask is nonzero. It follows the status and mask registers, with a delay of one clock after the event or the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| ale | input | 1 | Address latch strobe, falling edge captures |
| cs_n | input | 1 | Active-low chip select |
| wr_dir | input | 1 | 1 = write, 0 = read |
| lane1 | input | 1 | Address bit 1 (byte-lane select) |
| ad_in | input | 16 | Shared bus as seen by the slave |
| ad_out | output | 16 | Read data for the shared bus |
| bus_oe | output | 1 | Drive enable for ad_out |
| rdy_n | output | 1 | Active-low cycle ready |
| irq_n | output | 1 | Active-low interrupt |
| evt | input | 16 | Per-bit event pulses setting status |

## Verification
The bench counts clocks from the strobe's falling edge to low ready, so a design that miscounts wait phases or holds ready for two clocks is reported. It samples the output enable in every phase: a slave that drives in the strobe phase or the recovery phase would fight the master on the bus.

Odd and even word pairs differ only in `lane1`, so a slave that drops that bit aliases two scratch words. A write with chip select high, a write to the status word, and an unmapped address are each followed by read-backs; these catch slaves that decode too loosely. The status tests check that a masked event leaves the interrupt high, and that a partial clear releases only the written bit.

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int NWAIT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ale,
  input  logic        cs_n,
  input  logic        wr_dir,
  input  logic        lane1,
  input  logic [15:0] ad_in,
  output logic [15:0] ad_out,
  output logic        bus_oe,
  output logic        rdy_n,
  output logic        irq_n,
  input  logic [15:0] evt
);
  localparam int NSCR  = 5;
  localparam int IX_MASK = 5;
  localparam int IX_STAT = 6;
  localparam int IX_CLR  = 7;
  localparam int WCW = (NWAIT > 1) ? $clog2(NWAIT + 1) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_WAIT, S_DATA, S_REC} st_t;

  st_t             st;
  logic            ale_q, wr_q;
  logic [14:0]     a_hold, a_q;
  logic [WCW-1:0]  wcnt;
  logic [15:0]     scr [NSCR];
  logic [15:0]     mask, status, rd_val;

  wire       ale_fall = ale_q & ~ale;
  wire       mapped   = (a_q[14:3] == '0);
  wire [2:0] idx      = a_q[2:0];
  wire       do_wr    = (st == S_DATA) && wr_q && mapped;
  wire       do_rd    = (st == S_DATA) && !wr_q;
  wire [15:0] clr_bits = (do_wr && idx == 3'(IX_CLR)) ? ad_in : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ale_q  <= 1'b0;
      wr_q   <= 1'b0;
      a_hold <= '0;
      a_q    <= '0;
      wcnt   <= '0;
    end else begin
      ale_q <= ale;
      if (ale) a_hold <= {ad_in[15:2], lane1};
      case (st)
        S_IDLE: if (ale_fall && !cs_n) begin
          st   <= S_ACC;
          a_q  <= a_hold;
          wr_q <= wr_dir;
        end
        S_ACC: begin
          wcnt <= '0;
          st   <= (NWAIT == 0) ? S_DATA : S_WAIT;
        end
        S_WAIT: if (wcnt == WCW'(NWAIT - 1)) st <= S_DATA;
                else wcnt <= wcnt + 1'b1;
        S_DATA: st <= S_REC;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSCR; i++) scr[i] <= '0;
      mask   <= '0;
      status <= '0;
    end else begin
      for (int i = 0; i < NSCR; i++)
        if (do_wr && idx == 3'(i)) scr[i] <= ad_in;
      if (do_wr && idx == 3'(IX_MASK)) mask <= ad_in;
      status <= (status & ~clr_bits) | evt;
    end
  end

  always_comb begin
    rd_val = '0;
    if (mapped) begin
      if (int'(idx) < NSCR)           rd_val = scr[idx];
      else if (idx == 3'(IX_MASK))    rd_val = mask;
      else if (idx == 3'(IX_STAT))    rd_val = status;
      else                            rd_val = status & mask;
    end
  end

  assign ad_out = do_rd ? rd_val : 16'h0;
  assign bus_oe = do_rd;
  assign rdy_n  = (st != S_DATA);
  assign irq_n  = ~|(status & mask);

  // R5
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |=> rdy_n);
  // R5
  acc_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACC) |=> (st == ((NWAIT == 0) ? S_DATA : S_WAIT)));
  // R6
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!rdy_n && !wr_q));
  // R6
  rec_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |=> (st == S_REC && !bus_oe));
  // R3
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cs_n) |=> (st == S_IDLE));
  // R8
  stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && idx == 3'(IX_STAT) && evt == 16'h0) |=> (status == $past(status)));
endmodule

// File: tb/sim_mux_bus_slave.sv
module sim_mux_bus_slave;
  localparam int NW = 2;
  logic clk = 0, rst_n = 0, ale = 0, cs_n = 1, wr_dir = 0, lane1 = 0;
  logic [15:0] ad_in = 0, evt = 0;
  logic [15:0] ad_out;
  logic bus_oe, rdy_n, irq_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  mux_bus_slave #(.NWAIT(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .wr_dir(wr_dir),
    .lane1(lane1), .ad_in(ad_in), .ad_out(ad_out), .bus_oe(bus_oe),
    .rdy_n(rdy_n), .irq_n(irq_n), .evt(evt));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle; hi = ad[15:2], returns read data and clocks to ready
  task automatic cyc(input bit wr, input logic [13:0] hi, input bit ln,
                     input logic [15:0] wd, input bit csn,
                     output logic [15:0] rd, output int n);
    bit seen = 0;
    @(negedge clk);
    ale = 1; cs_n = csn; wr_dir = wr; lane1 = ln; ad_in = {hi, 2'b00};
    @(negedge clk);
    chk("R6 oe in strobe phase", bus_oe, 0);
    ale = 0; ad_in = wr ? wd : 16'h0;
    n = 0; rd = '0;
    while (!seen && n < 12) begin
      @(negedge clk); n++;
      if (!rdy_n) begin
        seen = 1; rd = ad_out;
        chk("R6 oe in data phase", bus_oe, !wr);
      end else chk("R6 oe outside data", bus_oe, 0);
    end
    if (seen) begin
      @(negedge clk);
      chk("R5 ready one clock", rdy_n, 1);
      chk("R6 oe released in recovery", bus_oe, 0);
    end else n = -1;
    cs_n = 1;
  endtask

  task automatic wr_ix(input int ix, input logic [15:0] d);
    logic [15:0] r; int n;
    cyc(1, 14'(ix >> 1), ix[0], d, 0, r, n);
  endtask

  task automatic rd_ix(input int ix, output logic [15:0] r);
    int n;
    cyc(0, 14'(ix >> 1), ix[0], 16'h0, 0, r, n);
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk("R1 rdy_n", rdy_n, 1);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 bus_oe", bus_oe, 0);
    for (int i = 0; i < 8; i++) begin
      rd_ix(i, r);
      chk("R1 reset value", r, 0);
    end
  endtask

  task automatic t_timing;
    logic [15:0] r; int n;
    cyc(1, 14'h0, 0, 16'h1234, 0, r, n);
    chk("R5 write wait count", n, NW + 2);
    cyc(0, 14'h0, 0, 16'h0, 0, r, n);
    chk("R5 read wait count", n, NW + 2);
    chk("R4 write then read", r, 16'h1234);
  endtask

  task automatic t_lanes;
    logic [15:0] r;
    wr_ix(2, 16'hA5A5);
    wr_ix(3, 16'h5A5A);
    wr_ix(4, 16'hC3C3);
    rd_ix(2, r); chk("R2 even word", r, 16'hA5A5);
    rd_ix(3, r); chk("R2 odd word via lane1", r, 16'h5A5A);
    rd_ix(4, r); chk("R8 scratch 4", r, 16'hC3C3);
  endtask

  task automatic t_cs;
    logic [15:0] r; int n;
    cyc(1, 14'h1, 0, 16'hDEAD, 1, r, n);
    chk("R3 no ready without cs", n, -1);
    rd_ix(2, r); chk("R3 location unchanged", r, 16'hA5A5);
  endtask

  task automatic t_unmapped;
    logic [15:0] r; int n;
    cyc(1, 14'h0100, 0, 16'hBEEF, 0, r, n);
    cyc(0, 14'h0100, 0, 16'h0, 0, r, n);
    chk("R7 unmapped read zero", r, 0);
    rd_ix(0, r); chk("R7 alias not written", r, 16'h1234);
  endtask

  task automatic t_irq;
    logic [15:0] r;
    wr_ix(5, 16'h0005);
    rd_ix(5, r); chk("R8 mask readback", r, 16'h0005);
    chk("R10 idle irq", irq_n, 1);
    @(negedge clk); evt = 16'h0004;
    @(negedge clk); evt = 16'h0;
    chk("R10 irq on enabled event", irq_n, 0);
    rd_ix(6, r); chk("R9 status set", r, 16'h0004);
    wr_ix(6, 16'hFFFF);
    rd_ix(6, r); chk("R8 status write ignored", r, 16'h0004);
    @(negedge clk); evt = 16'h0002;
    @(negedge clk); evt = 16'h0;
    wr_ix(7, 16'h0004);
    chk("R10 irq off, masked bit left", irq_n, 1);
    rd_ix(6, r); chk("R9 partial clear", r, 16'h0002);
    rd_ix(7, r); chk("R9 pending view", r, 16'h0000);
    wr_ix(5, 16'h0002);
    @(negedge clk);
    chk("R10 irq on mask change", irq_n, 0);
    wr_ix(7, 16'hFFFF);
    chk("R10 irq after clear all", irq_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_timing;
    t_lanes;
    t_cs;
    t_unmapped;
    t_irq;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); end
    join_any
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule